// File: doc/BRIEF.md
# Linear CCD Clock Timing Generator

This block derives every drive waveform for a dual-output linear CCD from a single system clock: an integration gate, a charge-reset pulse, a clamp pulse, a pair of complementary transfer clocks with a final-stage copy, a conversion strobe for an external sampler, and a one-cycle marker at the start of each readout line. An integration frame is a programmable number of clock cycles. The gate is high for the first part of each frame. The interval between two successive falling edges of the gate is the integration time.

At the start of each frame the pixel-rate machinery is cleared. It is then restarted after a fixed delay, with all waveforms placed at fixed offsets inside one shared pixel period. The reset pulse comes first, the clamp follows it, and the transfer clocks and conversion strobe come after the clamp. The transfer clocks run for a parameter number of pixels per frame. Reset and clamp each get one extra pulse. The frame length, gate width and pixel period are taken from configuration inputs only at a frame boundary, so a line is never disturbed partway through. The block has no data stream, so no valid/ready handshake applies. Every pin is a plain control strobe or configuration level.

With the default parameters and a 96 MHz clock, a frame of 480000 cycles with a 960-cycle gate and a 125-cycle pixel period gives 5 ms of integration and 3825 transfer cycles per line.

Top module: `ccd_timing_gen`

## Requirements
- R1: While reset is asserted or enable is low, the outputs rest at their idle levels: ph1_clk is 1, and sh_gate, line_start, rs_pulse, cp_pulse, ph2_clk, phb_clk and adc_trig are 0.
- R2: When enable is sampled high by a clock edge while the block is idle, a frame starts. Frame cycle s counts from 0 at that edge. All outputs are registered, so each output shows the state of cycle s one clock later. sh_gate is 1 for frame cycles 0 to W-1, where W is the latched gate width. A frame lasts exactly the latched period P, and the next frame follows without a gap.
- R3: line_start is 1 for exactly one cycle per frame, on frame cycle W, which is the first cycle after sh_gate falls.
- R4: rs_pulse is high for RS_W (9) cycles at the start of each pixel period. The first pixel period starts at frame cycle RS_DLY (19), and each pixel period lasts Q cycles, where Q is the latched pixel period. There are NPIX+1 reset pulses per frame.
- R5: cp_pulse has the same width and count as rs_pulse. Each clamp pulse starts CP_OFS (10) cycles after the start of its reset pulse.
- R6: ph2_clk is high for PH_W (15) cycles starting PH_OFS (29) cycles into each of the first NPIX pixel periods of a frame. phb_clk equals ph2_clk, and ph1_clk is always the inverse of ph2_clk.
- R7: adc_trig is a one-cycle strobe at PH_OFS+TRG_OFS (54) cycles into each of the first NPIX pixel periods. This is TRG_OFS (25) cycles after the rising edge of ph2_clk.
- R8: A change on cfg_period, cfg_sh_width or cfg_pix_period has no effect on the frame in progress. The new values take effect from the next frame start.
- R9: If enable is sampled low, the outputs are idle from the following cycle. A later rise of enable starts a new frame at frame cycle 0, using the configuration present at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Runs frames while high |
| cfg_period | input | PER_W | Frame length in cycles |
| cfg_sh_width | input | PER_W | Integration gate high time in cycles |
| cfg_pix_period | input | PIX_W | Pixel period in cycles |
| sh_gate | output | 1 | Integration / charge shift gate |
| rs_pulse | output | 1 | Charge reset pulse |
| cp_pulse | output | 1 | Output clamp pulse |
| ph1_clk | output | 1 | Transfer clock 1, inverse of ph2_clk |
| ph2_clk | output | 1 | Transfer clock 2 |
| phb_clk | output | 1 | Final-stage clock, identical to ph2_clk |
| adc_trig | output | 1 | One-cycle conversion strobe for the sampler |
| line_start | output | 1 | One-cycle marker at the falling edge of sh_gate |

## Verification
The width and spacing properties assume legal configuration values. These are: a gate width between 1 and P-1, a pixel period larger than PH_OFS+TRG_OFS, and a frame long enough to hold RS_DLY plus NPIX+1 pixel periods. Under these assumptions no pulse is ever cut short by a frame boundary. Only a drop of enable can truncate a pulse, so the width checks are suspended for two cycles after enable is low. The stimulus uses three configurations that meet these limits, including the minimum gate width of 1 and a pixel period just above the limit. It changes configuration only while a frame is running, and it drops enable partway through a line.

// File: rtl/ccd_timing_pkg.sv
package ccd_timing_pkg;

  // Registered drive word; ph1 is kept in its own register.
  typedef struct packed {
    logic sh;
    logic ls;
    logic rs;
    logic cp;
    logic ph2;
    logic trig;
  } ccd_drv_t;

  localparam ccd_drv_t DRV_IDLE = '0;

endpackage

// File: rtl/ccd_frame_ctrl.sv
module ccd_frame_ctrl #(
  parameter int PER_W  = 20,
  parameter int PIX_W  = 8,
  parameter int RS_DLY = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [PER_W-1:0] cfg_period,
  input  logic [PER_W-1:0] cfg_sh_width,
  input  logic [PIX_W-1:0] cfg_pix_period,
  output logic             run_q,
  output logic [PER_W-1:0] fcnt_q,
  output logic [PER_W-1:0] shw_q,
  output logic [PIX_W-1:0] pp_q,
  output logic             restart,
  output logic             pix_go
);

  localparam logic [PER_W-1:0] GO_AT = PER_W'(RS_DLY - 1);
  localparam logic [PER_W-1:0] ONE   = PER_W'(1);

  logic [PER_W-1:0] per_q;
  logic             at_end;

  always_comb begin
    at_end  = (fcnt_q == per_q - ONE);
    restart = !enable || !run_q || at_end;
    pix_go  = !restart && (fcnt_q == GO_AT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      fcnt_q <= '0;
      per_q  <= '0;
      shw_q  <= '0;
      pp_q   <= '0;
    end else if (!enable) begin
      run_q  <= 1'b0;
      fcnt_q <= '0;
    end else if (!run_q || at_end) begin
      run_q  <= 1'b1;
      fcnt_q <= '0;
      per_q  <= cfg_period;
      shw_q  <= cfg_sh_width;
      pp_q   <= cfg_pix_period;
    end else begin
      fcnt_q <= fcnt_q + ONE;
    end
  end

endmodule

// File: rtl/ccd_pixel_seq.sv
module ccd_pixel_seq #(
  parameter int PIX_W = 8,
  parameter int NPIX  = 3825,
  localparam int IDX_W = $clog2(NPIX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             pix_go,
  input  logic [PIX_W-1:0] pp_q,
  output logic             act_q,
  output logic [PIX_W-1:0] pos_q,
  output logic [IDX_W-1:0] idx_q
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NPIX);

  logic wrap;

  always_comb wrap = (pos_q == pp_q - PIX_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      pos_q <= '0;
      idx_q <= '0;
    end else if (restart) begin
      act_q <= 1'b0;
      pos_q <= '0;
      idx_q <= '0;
    end else if (pix_go) begin
      act_q <= 1'b1;
      pos_q <= '0;
      idx_q <= '0;
    end else if (act_q) begin
      if (wrap) begin
        pos_q <= '0;
        if (idx_q == LAST_IDX) act_q <= 1'b0;
        else                   idx_q <= idx_q + IDX_W'(1);
      end else begin
        pos_q <= pos_q + PIX_W'(1);
      end
    end
  end

endmodule

// File: rtl/ccd_wave_decode.sv
module ccd_wave_decode
  import ccd_timing_pkg::*;
#(
  parameter int PER_W   = 20,
  parameter int PIX_W   = 8,
  parameter int NPIX    = 3825,
  parameter int RS_W    = 9,
  parameter int CP_OFS  = 10,
  parameter int PH_OFS  = 29,
  parameter int PH_W    = 15,
  parameter int TRG_OFS = 25,
  localparam int IDX_W  = $clog2(NPIX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_q,
  input  logic [PER_W-1:0] fcnt_q,
  input  logic [PER_W-1:0] shw_q,
  input  logic             act_q,
  input  logic [PIX_W-1:0] pos_q,
  input  logic [IDX_W-1:0] idx_q,
  output ccd_drv_t         drv_q,
  output logic             ph1_q
);

  localparam logic [PIX_W-1:0] RS_HI  = PIX_W'(RS_W);
  localparam logic [PIX_W-1:0] CP_LO  = PIX_W'(CP_OFS);
  localparam logic [PIX_W-1:0] CP_HI  = PIX_W'(CP_OFS + RS_W);
  localparam logic [PIX_W-1:0] PH_LO  = PIX_W'(PH_OFS);
  localparam logic [PIX_W-1:0] PH_HI  = PIX_W'(PH_OFS + PH_W);
  localparam logic [PIX_W-1:0] TRG_AT = PIX_W'(PH_OFS + TRG_OFS);
  localparam logic [IDX_W-1:0] N_PH   = IDX_W'(NPIX);

  ccd_drv_t drv_d;
  logic     ph_win;

  always_comb begin
    ph_win     = act_q && (idx_q < N_PH);
    drv_d.sh   = run_q && (fcnt_q < shw_q);
    drv_d.ls   = run_q && (fcnt_q == shw_q);
    drv_d.rs   = act_q && (pos_q < RS_HI);
    drv_d.cp   = act_q && (pos_q >= CP_LO) && (pos_q < CP_HI);
    drv_d.ph2  = ph_win && (pos_q >= PH_LO) && (pos_q < PH_HI);
    drv_d.trig = ph_win && (pos_q == TRG_AT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_q <= DRV_IDLE;
      ph1_q <= 1'b1;
    end else begin
      drv_q <= drv_d;
      ph1_q <= !(ph_win && (pos_q >= PH_LO) && (pos_q < PH_HI));
    end
  end

endmodule

// File: rtl/ccd_timing_gen.sv
module ccd_timing_gen
  import ccd_timing_pkg::*;
#(
  parameter int PER_W   = 20,
  parameter int PIX_W   = 8,
  parameter int NPIX    = 3825,
  parameter int RS_DLY  = 19,
  parameter int RS_W    = 9,
  parameter int CP_OFS  = 10,
  parameter int PH_OFS  = 29,
  parameter int PH_W    = 15,
  parameter int TRG_OFS = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [PER_W-1:0] cfg_period,
  input  logic [PER_W-1:0] cfg_sh_width,
  input  logic [PIX_W-1:0] cfg_pix_period,
  output logic             sh_gate,
  output logic             rs_pulse,
  output logic             cp_pulse,
  output logic             ph1_clk,
  output logic             ph2_clk,
  output logic             phb_clk,
  output logic             adc_trig,
  output logic             line_start
);

  localparam int IDX_W = $clog2(NPIX + 1);

  logic             run_q, restart, pix_go, act_q, ph1_q;
  logic [PER_W-1:0] fcnt_q, shw_q;
  logic [PIX_W-1:0] pp_q, pos_q;
  logic [IDX_W-1:0] idx_q;
  ccd_drv_t         drv_q;

  ccd_frame_ctrl #(.PER_W(PER_W), .PIX_W(PIX_W), .RS_DLY(RS_DLY)) u_frame (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .cfg_period(cfg_period), .cfg_sh_width(cfg_sh_width),
    .cfg_pix_period(cfg_pix_period),
    .run_q(run_q), .fcnt_q(fcnt_q), .shw_q(shw_q), .pp_q(pp_q),
    .restart(restart), .pix_go(pix_go)
  );

  ccd_pixel_seq #(.PIX_W(PIX_W), .NPIX(NPIX)) u_pixel (
    .clk(clk), .rst_n(rst_n), .restart(restart), .pix_go(pix_go),
    .pp_q(pp_q), .act_q(act_q), .pos_q(pos_q), .idx_q(idx_q)
  );

  ccd_wave_decode #(
    .PER_W(PER_W), .PIX_W(PIX_W), .NPIX(NPIX), .RS_W(RS_W), .CP_OFS(CP_OFS),
    .PH_OFS(PH_OFS), .PH_W(PH_W), .TRG_OFS(TRG_OFS)
  ) u_wave (
    .clk(clk), .rst_n(rst_n), .run_q(run_q), .fcnt_q(fcnt_q), .shw_q(shw_q),
    .act_q(act_q), .pos_q(pos_q), .idx_q(idx_q), .drv_q(drv_q), .ph1_q(ph1_q)
  );

  assign sh_gate    = drv_q.sh;
  assign line_start = drv_q.ls;
  assign rs_pulse   = drv_q.rs;
  assign cp_pulse   = drv_q.cp;
  assign ph2_clk    = drv_q.ph2;
  assign phb_clk    = drv_q.ph2;
  assign adc_trig   = drv_q.trig;
  assign ph1_clk    = ph1_q;

endmodule

// File: rtl/ccd_timing_chk.sv
module ccd_timing_chk #(
  parameter int RS_W    = 9,
  parameter int CP_OFS  = 10,
  parameter int PH_W    = 15,
  parameter int TRG_OFS = 25
) (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic sh_gate,
  input logic line_start,
  input logic rs_pulse,
  input logic cp_pulse,
  input logic ph1_clk,
  input logic ph2_clk,
  input logic adc_trig
);

  logic [7:0] rs_len, ph_len, rs_age, ph_age;
  logic       rs_prev, ph_prev;

  function automatic logic [7:0] sat_inc(input logic [7:0] x);
    return (x == 8'hFF) ? x : x + 8'd1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_len <= '0; ph_len <= '0; rs_age <= '0; ph_age <= '0;
      rs_prev <= 1'b0; ph_prev <= 1'b0;
    end else begin
      rs_prev <= rs_pulse;
      ph_prev <= ph2_clk;
      rs_len  <= rs_pulse ? sat_inc(rs_len) : 8'd0;
      ph_len  <= ph2_clk  ? sat_inc(ph_len) : 8'd0;
      rs_age  <= (rs_pulse && !rs_prev) ? 8'd1 : sat_inc(rs_age);
      ph_age  <= (ph2_clk && !ph_prev)  ? 8'd1 : sat_inc(ph_age);
    end
  end

  a_r1_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> ##2 (ph1_clk && !sh_gate && !line_start && !rs_pulse &&
                     !cp_pulse && !ph2_clk && !adc_trig));

  a_r3_ls_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> !line_start);

  a_r3_ls_at_gate_fall: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sh_gate) && $past(enable, 2)) |-> line_start);

  a_r4_rs_width: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rs_pulse) && $past(enable, 2)) |-> (rs_len == 8'(RS_W)));

  a_r5_cp_offset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cp_pulse) |-> (rs_age == 8'(CP_OFS)));

  a_r6_ph_width: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ph2_clk) && $past(enable, 2)) |-> (ph_len == 8'(PH_W)));

  a_r6_ph_complement: assert property (@(posedge clk) disable iff (!rst_n)
    ph1_clk != ph2_clk);

  a_r7_trig_offset: assert property (@(posedge clk) disable iff (!rst_n)
    adc_trig |-> (ph_age == 8'(TRG_OFS)));

  a_r7_trig_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    adc_trig |=> !adc_trig);

endmodule

bind ccd_timing_gen ccd_timing_chk #(
  .RS_W(RS_W), .CP_OFS(CP_OFS), .PH_W(PH_W), .TRG_OFS(TRG_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .sh_gate(sh_gate),
  .line_start(line_start), .rs_pulse(rs_pulse), .cp_pulse(cp_pulse),
  .ph1_clk(ph1_clk), .ph2_clk(ph2_clk), .adc_trig(adc_trig)
);

// File: tb/ccd_timing_gen_test.sv
module ccd_timing_gen_test;

  localparam int PER_W = 20, PIX_W = 8, NPIX = 4, RS_DLY = 19, RS_W = 9;
  localparam int CP_OFS = 10, PH_OFS = 29, PH_W = 15, TRG_OFS = 25;

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0;
  logic [PER_W-1:0] cfg_period = '0, cfg_sh_width = '0;
  logic [PIX_W-1:0] cfg_pix_period = '0;
  logic sh_gate, rs_pulse, cp_pulse, ph1_clk, ph2_clk, phb_clk, adc_trig, line_start;

  always #2 clk = ~clk;

  ccd_timing_gen #(
    .PER_W(PER_W), .PIX_W(PIX_W), .NPIX(NPIX), .RS_DLY(RS_DLY), .RS_W(RS_W),
    .CP_OFS(CP_OFS), .PH_OFS(PH_OFS), .PH_W(PH_W), .TRG_OFS(TRG_OFS)
  ) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_period(cfg_period),
    .cfg_sh_width(cfg_sh_width), .cfg_pix_period(cfg_pix_period),
    .sh_gate(sh_gate), .rs_pulse(rs_pulse), .cp_pulse(cp_pulse),
    .ph1_clk(ph1_clk), .ph2_clk(ph2_clk), .phb_clk(phb_clk),
    .adc_trig(adc_trig), .line_start(line_start)
  );

  // Vector bits: 7 sh, 6 ls, 5 rs, 4 cp, 3 ph1, 2 ph2, 1 phb, 0 trig
  typedef struct { logic [7:0] v; string tag; } item_t;
  item_t q[$];
  int checks = 0, failures = 0;
  int rises[8];
  logic [7:0] prev_v = 8'h08;
  string phase_tag = "R1";
  string fname[8] = '{"trig", "phb", "ph2", "ph1", "cp", "rs", "ls", "sh"};
  string freq[8]  = '{"R7", "R6", "R6", "R6", "R5", "R4", "R3", "R2"};

  // Reference frame model, built from the requirement text.
  bit m_run = 1'b0;
  int m_s = 0, m_per = 0, m_shw = 0, m_pp = 1;

  function automatic logic [7:0] expect_vec();
    int a, k, r;
    logic sh, ls, rs, cp, ph2, tr;
    if (!m_run) return 8'h08;
    sh = (m_s < m_shw);
    ls = (m_s == m_shw);
    rs = 0; cp = 0; ph2 = 0; tr = 0;
    a = m_s - RS_DLY;
    if (a >= 0 && a < (NPIX + 1) * m_pp) begin
      k = a / m_pp;
      r = a % m_pp;
      rs  = (r < RS_W);
      cp  = (r >= CP_OFS) && (r < CP_OFS + RS_W);
      ph2 = (k < NPIX) && (r >= PH_OFS) && (r < PH_OFS + PH_W);
      tr  = (k < NPIX) && (r == PH_OFS + TRG_OFS);
    end
    return {sh, ls, rs, cp, !ph2, ph2, ph2, tr};
  endfunction

  task automatic step(input bit en);
    @(negedge clk);
    q.push_back('{expect_vec(), phase_tag});
    enable = en;
    if (!en) begin
      m_run = 0; m_s = 0;
    end else if (!m_run || m_s == m_per - 1) begin
      m_run = 1; m_s = 0;
      m_per = int'(cfg_period); m_shw = int'(cfg_sh_width); m_pp = int'(cfg_pix_period);
    end else begin
      m_s++;
    end
  endtask

  task automatic steps(input int n, input bit en);
    for (int i = 0; i < n; i++) step(en);
  endtask

  task automatic set_cfg(input int p, input int w, input int pp);
    cfg_period = PER_W'(p); cfg_sh_width = PER_W'(w); cfg_pix_period = PIX_W'(pp);
  endtask

  task automatic check_int(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: pops one expected vector per cycle and compares field by field.
  initial begin
    forever begin
      @(posedge clk); #1;
      if (q.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it  = q.pop_front();
        act = {sh_gate, line_start, rs_pulse, cp_pulse, ph1_clk, ph2_clk, phb_clk, adc_trig};
        for (int b = 0; b < 8; b++) begin
          checks++;
          if (act[b] !== it.v[b]) begin
            failures++;
            $display("FAIL %s (phase %s) %s at %0t: actual=%b expected=%b",
                     freq[b], it.tag, fname[b], $time, act[b], it.v[b]);
          end
          if (act[b] && !prev_v[b]) rises[b]++;
        end
        prev_v = act;
      end
    end
  end

  bit done = 0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: idle levels during reset
    repeat (3) @(negedge clk);
    check_int("R1 ph1 in reset", int'(ph1_clk), 1);
    check_int("R1 sh in reset", int'(sh_gate), 0);
    check_int("R1 rs/cp in reset", int'(rs_pulse | cp_pulse), 0);
    check_int("R1 ph2/phb/trig/ls in reset", int'(ph2_clk | phb_clk | adc_trig | line_start), 0);
    rst_n = 1'b1;

    phase_tag = "R1";
    set_cfg(400, 10, 64);
    steps(6, 1'b0);

    // R2: continuous frames with config A
    phase_tag = "R2";
    steps(600, 1'b1);

    // R8: change config mid-frame; takes effect at next frame start
    phase_tag = "R8";
    set_cfg(450, 12, 70);
    steps(750, 1'b1);

    // R9: drop enable mid-line, then restart
    phase_tag = "R9";
    steps(30, 1'b0);
    steps(170, 1'b1);
    set_cfg(300, 1, 55);
    steps(430, 1'b1);

    // Counting one clean frame (R3..R7)
    phase_tag = "R2";
    steps(5, 1'b0);
    set_cfg(400, 10, 64);
    @(posedge clk); #2;
    for (int b = 0; b < 8; b++) rises[b] = 0;
    steps(400, 1'b1);
    steps(5, 1'b0);
    @(posedge clk); #2;
    check_int("R2 gate pulses per frame", rises[7], 1);
    check_int("R3 line_start per frame", rises[6], 1);
    check_int("R4 reset pulses per frame", rises[5], NPIX + 1);
    check_int("R5 clamp pulses per frame", rises[4], NPIX + 1);
    check_int("R6 phase2 cycles per frame", rises[2], NPIX);
    check_int("R6 final-stage cycles per frame", rises[1], NPIX);
    check_int("R7 triggers per frame", rises[0], NPIX);
    check_int("R1 queue drained", q.size(), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule